// File: doc/BRIEF.md
# Write Status Polling Generator

This block sits in the read path of a parallel NOR-style flash controller model. When the command logic launches an internal word program or an erase, the block holds a busy interval whose length is a per-operation cycle count. While the operation is busy, every read returns a status word instead of array contents. Bit 7 is a completion flag, and its meaning depends on the operation kind. Bit 6 flips on every read and so shows that the operation is still running. The remaining bits come from the word latched when the operation was launched. Once the interval ends, reads return ordinary array data again.

The command logic pulses `op_start` on the write strobe that launches the operation. For a program that is the fourth bus write and for an erase the sixth. Along with the pulse it supplies the operation kind and the program word. In the last busy cycle the block raises `done` for one cycle, so that the command logic can commit the array update. Reads are synchronous: a strobe in one cycle returns its word on `rd_data` in the next cycle, and `rd_data` holds that word until the next strobe.

Top module: `wsp_status_gen`

## Requirements
- R1: While reset is asserted, `rd_data` is 0 and both `busy` and `done` are 0.
- R2: An `op_start` sampled while idle raises `busy` in the next cycle. `busy` then stays high for exactly the cycle count of the selected kind: PROG_CYC, SECT_CYC, BLK_CYC or CHIP_CYC.
- R3: `done` is high for exactly one cycle, which is the last cycle of the busy interval, and `busy` is low in the cycle after it.
- R4: An `op_start` sampled while busy is ignored. It does not change the interval length, the latched kind or the latched word.
- R5: A read during a program returns the complement of bit 7 of the latched program word in bit 7.
- R6: A read during any erase kind (sector, block or chip) returns 0 in bit 7.
- R7: During a busy interval, bit 6 of the read word is 1 on the first read after launch and flips on each further read, including reads on back-to-back cycles.
- R8: During a busy interval, bits 15:8 and 5:0 of the read word equal the same bits of the word latched at launch.
- R9: A read sampled while idle returns `array_rdata` as sampled with the strobe. `rd_data` changes only on the cycle after a strobe.
- R10: The `op_kind` encoding is 0 = word program, 1 = sector erase, 2 = block erase, 3 = chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_start | input | 1 | One-cycle launch strobe from the command logic |
| op_kind | input | 2 | Operation kind sampled with op_start (R10 encoding) |
| op_wdata | input | DATA_W | Program word sampled with op_start |
| rd_stb | input | 1 | Synchronous read strobe |
| array_rdata | input | DATA_W | Word from the array storage at the read address |
| rd_data | output | DATA_W | Read result, valid the cycle after rd_stb |
| busy | output | 1 | Internal operation in progress |
| done | output | 1 | One-cycle pulse in the final busy cycle |

## Verification
If a launch is sampled at clock edge s, `busy` is high from edge s up to edge s+N-1, where N is the kind's cycle count. `done` is high only after edge s+N-1, and a read sampled at edges s+1 through s+N gets the status word. The bench numbers every rising edge and works out each expected read word from the edge index at which its strobe will be sampled. It queues that word, then pops and compares it half a cycle after the following edge. `busy` and `done` are compared against the same edge-index model at every falling edge, so the launch edge, the done edge, a read on the final busy edge and the first idle read are all checked exactly.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_CHIP  = 2'd3
  } wsp_op_e;

  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;

  // Completion flag while busy: inverted write bit for a program, 0 for erase.
  function automatic logic poll_flag(input wsp_op_e op, input logic wbit);
    return (op == OP_PROG) ? ~wbit : 1'b0;
  endfunction

endpackage

// File: rtl/wsp_rst_sync.sv
module wsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wsp_op_timer.sv
module wsp_op_timer
  import wsp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PROG_CYC = 500,
  parameter int unsigned SECT_CYC = 200000,
  parameter int unsigned BLK_CYC  = 500000,
  parameter int unsigned CHIP_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  wsp_op_e           op,
  input  logic [DATA_W-1:0] wdata,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output wsp_op_e           lat_op,
  output logic [DATA_W-1:0] lat_data
);
  localparam int unsigned MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int unsigned MAX_B = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW    = $clog2(MAX_C + 1);

  function automatic logic [CW-1:0] last_count(input wsp_op_e k);
    case (k)
      OP_PROG:  return CW'(PROG_CYC - 1);
      OP_SECT:  return CW'(SECT_CYC - 1);
      OP_BLOCK: return CW'(BLK_CYC - 1);
      default:  return CW'(CHIP_CYC - 1);
    endcase
  endfunction

  logic [CW-1:0]     cnt_q, cnt_d;
  logic              busy_q, busy_d;
  wsp_op_e           op_q, op_d;
  logic [DATA_W-1:0] data_q, data_d;

  assign accept = start && !busy_q;
  assign done   = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    op_d   = op_q;
    data_d = data_q;
    if (accept) begin
      cnt_d  = last_count(op);
      busy_d = 1'b1;
      op_d   = op;
      data_d = wdata;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      op_q   <= OP_PROG;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      op_q   <= op_d;
      data_q <= data_d;
    end
  end

  assign busy     = busy_q;
  assign lat_op   = op_q;
  assign lat_data = data_q;

  // Independent length counter for the duration check.
  logic [CW-1:0] chk_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           chk_len_q <= '0;
    else if (accept)      chk_len_q <= '0;
    else if (busy_q)      chk_len_q <= chk_len_q + 1'b1;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_len_q == last_count(op_q)));
  p_start_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_busy_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
  p_ignore_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(lat_data) && $stable(lat_op)));
endmodule

// File: rtl/wsp_toggle.sv
module wsp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic rd_stb,
  input  logic busy,
  output logic tog
);
  logic tog_q, tog_d;

  always_comb begin
    tog_d = tog_q;
    if (accept)              tog_d = 1'b1;
    else if (rd_stb && busy) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b1;
    else        tog_q <= tog_d;
  end

  assign tog = tog_q;

  p_first_read_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tog);
  p_flip_per_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && !accept) |=> (tog != $past(tog)));
endmodule

// File: rtl/wsp_read_mux.sv
module wsp_read_mux
  import wsp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              busy,
  input  wsp_op_e           lat_op,
  input  logic [DATA_W-1:0] lat_data,
  input  logic              tog,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_q, rd_d;

  always_comb begin
    rd_d = rd_q;
    if (rd_stb) begin
      if (busy) begin
        rd_d             = lat_data;
        rd_d[POLL_BIT]   = poll_flag(lat_op, lat_data[POLL_BIT]);
        rd_d[TOGGLE_BIT] = tog;
      end else begin
        rd_d = array_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  p_erase_flag_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && lat_op != OP_PROG) |=> !rd_data[POLL_BIT]);
  p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy) |=> (rd_data == $past(array_rdata)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: rtl/wsp_status_gen.sv
module wsp_status_gen
  import wsp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PROG_CYC = 500,
  parameter int unsigned SECT_CYC = 200000,
  parameter int unsigned BLK_CYC  = 500000,
  parameter int unsigned CHIP_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);
  logic              rst_n_i;
  logic              accept;
  logic              tog;
  wsp_op_e           lat_op;
  logic [DATA_W-1:0] lat_data;

  wsp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  wsp_op_timer #(
    .DATA_W   (DATA_W),
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .BLK_CYC  (BLK_CYC),
    .CHIP_CYC (CHIP_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (op_start),
    .op       (wsp_op_e'(op_kind)),
    .wdata    (op_wdata),
    .accept   (accept),
    .busy     (busy),
    .done     (done),
    .lat_op   (lat_op),
    .lat_data (lat_data)
  );

  wsp_toggle u_toggle (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .accept (accept),
    .rd_stb (rd_stb),
    .busy   (busy),
    .tog    (tog)
  );

  wsp_read_mux #(
    .DATA_W (DATA_W)
  ) u_mux (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .rd_stb      (rd_stb),
    .busy        (busy),
    .lat_op      (lat_op),
    .lat_data    (lat_data),
    .tog         (tog),
    .array_rdata (array_rdata),
    .rd_data     (rd_data)
  );
endmodule

// File: tb/wsp_status_gen_bench.sv
module wsp_status_gen_bench;
  localparam int DW     = 16;
  localparam int C_PROG = 6;
  localparam int C_SECT = 9;
  localparam int C_BLK  = 12;
  localparam int C_CHIP = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_start = 1'b0;
  logic [1:0]    op_kind = 2'd0;
  logic [DW-1:0] op_wdata = '0;
  logic          rd_stb = 1'b0;
  logic [DW-1:0] arr = '0;
  logic [DW-1:0] rd_data;
  logic          busy, done;

  always #10 clk = ~clk;

  wsp_status_gen #(
    .DATA_W (DW), .PROG_CYC (C_PROG), .SECT_CYC (C_SECT),
    .BLK_CYC (C_BLK), .CHIP_CYC (C_CHIP)
  ) u_wsp_status_gen (
    .clk (clk), .rst_n (rst_n), .op_start (op_start), .op_kind (op_kind),
    .op_wdata (op_wdata), .rd_stb (rd_stb), .array_rdata (arr),
    .rd_data (rd_data), .busy (busy), .done (done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model, indexed by rising-edge number.
  int            m_s = 0;
  int            m_dur = 0;
  bit            m_started = 1'b0;
  logic [1:0]    m_op = 2'd0;
  logic [DW-1:0] m_data = '0;
  bit            m_tog = 1'b1;
  bit            mon_on = 1'b0;
  logic [DW-1:0] last_exp = '0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  function automatic int dur_of(input logic [1:0] k);
    case (k)
      2'd0: return C_PROG;
      2'd1: return C_SECT;
      2'd2: return C_BLK;
      default: return C_CHIP;
    endcase
  endfunction

  function automatic bit busy_at(input int p);
    return m_started && (p >= m_s + 1) && (p <= m_s + m_dur);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (edge %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Per-cycle monitor for busy and done (R2, R3).
  always @(negedge clk) begin
    if (mon_on) begin
      bit eb, ed;
      eb = m_started && (cyc >= m_s) && (cyc <= m_s + m_dur - 1);
      ed = m_started && (cyc == m_s + m_dur - 1);
      chk(busy == eb, "R2 busy", {31'd0, busy}, {31'd0, eb});
      chk(done == ed, "R3 done", {31'd0, done}, {31'd0, ed});
    end
  end

  // Scoreboard monitor: the word is due one edge after the strobe.
  logic pend = 1'b0;
  always @(posedge clk) pend <= rd_stb;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 queue", {16'd0, rd_data}, 32'd0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, {16'd0, rd_data}, {16'd0, e});
      end
    end
  end

  // Watchdog
  always @(negedge clk) begin
    if (cyc > 5000 && !finished) begin
      chk(1'b0, "watchdog", cyc, 5000);
      finish_run();
    end
  end

  task automatic do_start(input logic [1:0] k, input logic [DW-1:0] d);
    int p;
    p = cyc + 1;
    op_start = 1'b1;
    op_kind  = k;
    op_wdata = d;
    if (!busy_at(p)) begin
      m_s = p; m_dur = dur_of(k); m_op = k; m_data = d;
      m_started = 1'b1; m_tog = 1'b1;
    end
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic do_reads(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int p;
      logic [DW-1:0] e;
      p = cyc + 1;
      rd_stb = 1'b1;
      if (busy_at(p)) begin
        e = m_data;
        e[7] = (m_op == 2'd0) ? ~m_data[7] : 1'b0;
        e[6] = m_tog;
        m_tog = ~m_tog;
      end else begin
        e = arr;
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
      last_exp = e;
      @(negedge clk);
    end
    rd_stb = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_started && (cyc + 1 <= m_s + m_dur)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rd_data == '0, "R1 rd_data", {16'd0, rd_data}, 32'd0);
    chk(busy == 1'b0, "R1 busy", {31'd0, busy}, 32'd0);
    chk(done == 1'b0, "R1 done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R9: idle reads pass the array word through
    arr = 16'hA5C3; do_reads(1, "R9 idle read");
    arr = 16'h0F0F; do_reads(1, "R9 idle read");
    // R9: hold without strobe
    @(negedge clk);
    arr = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(rd_data == last_exp, "R9 hold", {16'd0, rd_data}, {16'd0, last_exp});

    // R5 R7 R8: program with bit 7 set, back-to-back reads
    arr = 16'h1111;
    do_start(2'd0, 16'h5A80);
    do_reads(3, "R5 R7 R8 program");
    // Read on the final busy edge, then the first idle read
    while (cyc + 1 < m_s + m_dur) @(negedge clk);
    do_reads(1, "R3 R5 last busy read");
    do_reads(1, "R9 first idle read");
    wait_idle();

    // R5: program with bit 7 clear, reads spaced out
    arr = 16'h2222;
    do_start(2'd0, 16'h1234);
    do_reads(1, "R5 R7 program");
    @(negedge clk);
    do_reads(1, "R5 R7 program");
    @(negedge clk);
    do_reads(1, "R5 R7 R8 program");
    wait_idle();
    do_reads(1, "R9 after program");

    // R6 R10: sector erase, plus a start while busy (R4)
    arr = 16'h3333;
    do_start(2'd1, 16'hFFFF);
    do_reads(2, "R6 R7 sector erase");
    do_start(2'd0, 16'h0000);
    do_reads(2, "R4 R6 start ignored");
    wait_idle();
    do_reads(1, "R9 after sector");

    // R6 R10: block erase
    arr = 16'h4444;
    do_start(2'd2, 16'hC3FF);
    do_reads(4, "R6 R7 R8 block erase");
    wait_idle();

    // R6 R10: chip erase, R7 restart of toggle at launch
    arr = 16'h5555;
    do_start(2'd3, 16'h00BF);
    do_reads(1, "R6 R7 chip erase first");
    repeat (2) @(negedge clk);
    do_reads(2, "R6 R7 chip erase");
    wait_idle();
    do_reads(1, "R9 after chip");

    // R2: launch right after done (back-to-back operations)
    do_start(2'd0, 16'h0080);
    while (cyc + 1 <= m_s + m_dur) @(negedge clk);
    do_start(2'd1, 16'hABCD);
    do_reads(1, "R2 R6 R7 relaunch");
    wait_idle();

    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    if (exp_q.size() != 0) chk(1'b0, "R9 pending", exp_q.size(), 0);
    finish_run();
  end
endmodule